// File: doc/BRIEF.md
# Source-Routed Packet Crossbar Switch

This block is a lossless packet switch that joins a set of endpoints (processor cores, chip-to-chip link adapters) on one die. Every port, in and out, is a word stream with valid, ready and a last-word marker. A packet is one or more words. The first word is the header, and it carries the whole route chosen by the sender as a chain of small port fields. The switch keeps no routing tables: each hop consumes the lowest field and passes the rest on.

Each input has its own buffer. The buffer queues arriving words and decodes the destination of the packet at its head. A crossbar moves words from buffers to outputs. Every output has its own round-robin arbiter. Once that arbiter grants an input, it keeps the path for the whole packet. Nothing is ever discarded. A blocked path stalls the sender through ready. Integrity checking and retransmission are left to the endpoints.

Top module: `psw_switch`

## Requirements
- R1: The low PORT_BITS bits of a header word (the first word of a packet) give the index of the output port that carries the whole packet.
- R2: On the output, the header leaves shifted right by PORT_BITS bits with zeros filled in at the top, so the next hop finds its own field in the low bits. Non-header words leave unchanged.
- R3: No word is lost, duplicated or reordered. Each input buffer holds DEPTH words and drops in_ready when it is full and no word is leaving it.
- R4: Once an output has forwarded a header from an input, it carries only that input's words, in order, until the word marked last has passed. At most one output reads from any input in a cycle.
- R5: Arbitration is round-robin. After reset the search starts at input 0. After a grant to input i, the next search starts at input i+1, wrapping past the highest index.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle.
- R7: A full input buffer raises in_ready in a cycle in which its head word is being forwarded, and it accepts a new word in that same cycle.
- R8: After reset, all out_valid are low and all in_ready are high.
- R9: Packets going to different outputs move in the same cycle without waiting for each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NUM_PORTS | Word offered on each input |
| in_data | input | NUM_PORTS x DATA_W | Input words |
| in_last | input | NUM_PORTS | Marks the final word of a packet |
| in_ready | output | NUM_PORTS | Input can take a word this cycle |
| out_valid | output | NUM_PORTS | Word offered on each output |
| out_data | output | NUM_PORTS x DATA_W | Output words, headers shifted |
| out_last | output | NUM_PORTS | Marks the final word of a packet |
| out_ready | input | NUM_PORTS | Receiver takes the word this cycle |

## Verification
The bench builds the switch with PORT_BITS=2 (four ports), DATA_W=16 and DEPTH=4. With only four buffer slots, a stalled output fills its input within a few cycles, so the full-buffer stall and the case of reading and writing in the same cycle come up often under random traffic. Four inputs give the round-robin pointer a short cycle, so directed bursts can show that it wraps. The narrow header lets each packet carry its source index in the field the next hop would read.

// File: rtl/psw_pkg.sv
package psw_pkg;

    // Output arbiter state: searching for a requester, or holding a path.
    typedef enum logic {
        ARB_IDLE   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/psw_in_buffer.sv
module psw_in_buffer #(
    parameter int DATA_W    = 32,
    parameter int PORT_BITS = 3,
    parameter int DEPTH     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic                 head_valid,
    output logic [DATA_W-1:0]    head_data,
    output logic                 head_last,
    output logic                 head_sop,
    output logic [PORT_BITS-1:0] head_dest,
    input  logic                 pop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          sop;
    } buf_state_t;

    buf_state_t s_q, s_d;
    logic [DATA_W:0] mem_q [DEPTH];
    logic            push;
    logic [DATA_W:0] head_word;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        head_word = mem_q[s_q.rd_ptr];
        in_ready  = (s_q.count != CW'(DEPTH)) || pop;
        push      = in_valid && in_ready;

        head_valid = (s_q.count != '0);
        head_last  = head_word[DATA_W];
        head_sop   = s_q.sop;
        head_dest  = head_word[PORT_BITS-1:0];
        head_data  = s_q.sop ? (head_word[DATA_W-1:0] >> PORT_BITS) : head_word[DATA_W-1:0];

        if (push) begin
            s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
        end
        if (pop) begin
            s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
            s_d.sop    = head_word[DATA_W];
        end
        case ({push, pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr_ptr: '0, rd_ptr: '0, count: '0, sop: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[s_q.wr_ptr] <= {in_last, in_data};
        end
    end

    // R3: storage never holds more than DEPTH words
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    // R3: a read is only ever taken from a non-empty buffer
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/psw_out_arbiter.sv
module psw_out_arbiter
    import psw_pkg::*;
#(
    parameter int NUM_IN = 8,
    localparam int IW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] req,
    input  logic              xfer,
    input  logic              xfer_last,
    output logic              owner_vld,
    output logic [IW-1:0]     owner_idx
);

    typedef struct packed {
        arb_state_e    state;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } arb_t;

    arb_t a_q, a_d;
    logic          found;
    logic [IW-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = a_q.ptr;
        for (int k = 0; k < NUM_IN; k++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(a_q.ptr) + k) % NUM_IN);
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end

        owner_idx = (a_q.state == ARB_LOCKED) ? a_q.owner : pick;
        owner_vld = (a_q.state == ARB_LOCKED) || found;

        a_d = a_q;
        if (owner_vld) begin
            a_d.state = (xfer && xfer_last) ? ARB_IDLE : ARB_LOCKED;
            a_d.owner = owner_idx;
            if (a_q.state == ARB_IDLE) begin
                a_d.ptr = (pick == IW'(NUM_IN - 1)) ? '0 : pick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '{state: ARB_IDLE, owner: '0, ptr: '0};
        end else begin
            a_q <= a_d;
        end
    end

    // R4: a held path keeps its owner until the last word has passed
    assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.state == ARB_LOCKED && !(xfer && xfer_last))
        |=> (a_q.state == ARB_LOCKED && a_q.owner == $past(a_q.owner)));

    // R4: words move only along a granted path
    assert_xfer_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> owner_vld);

endmodule

// File: rtl/psw_switch.sv
module psw_switch #(
    parameter int DATA_W     = 32,
    parameter int PORT_BITS  = 3,
    parameter int DEPTH      = 16,
    localparam int NUM_PORTS = 1 << PORT_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0]                in_valid,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    in_data,
    input  logic [NUM_PORTS-1:0]                in_last,
    output logic [NUM_PORTS-1:0]                in_ready,
    output logic [NUM_PORTS-1:0]                out_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    out_data,
    output logic [NUM_PORTS-1:0]                out_last,
    input  logic [NUM_PORTS-1:0]                out_ready
);

    logic [NUM_PORTS-1:0]    hd_valid;
    logic [NUM_PORTS-1:0]    hd_last;
    logic [NUM_PORTS-1:0]    hd_sop;
    logic [NUM_PORTS-1:0]    pop;
    logic [DATA_W-1:0]       hd_data [NUM_PORTS];
    logic [PORT_BITS-1:0]    hd_dest [NUM_PORTS];

    logic [NUM_PORTS-1:0]    req     [NUM_PORTS];
    logic [NUM_PORTS-1:0]    rd_by   [NUM_PORTS];
    logic [NUM_PORTS-1:0]    own_vld;
    logic [PORT_BITS-1:0]    own_idx [NUM_PORTS];
    logic [NUM_PORTS-1:0]    fire;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
        psw_in_buffer #(
            .DATA_W    (DATA_W),
            .PORT_BITS (PORT_BITS),
            .DEPTH     (DEPTH)
        ) buf_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[i]),
            .in_data    (in_data[i]),
            .in_last    (in_last[i]),
            .in_ready   (in_ready[i]),
            .head_valid (hd_valid[i]),
            .head_data  (hd_data[i]),
            .head_last  (hd_last[i]),
            .head_sop   (hd_sop[i]),
            .head_dest  (hd_dest[i]),
            .pop        (pop[i])
        );
    end

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                req[o][i] = hd_valid[i] && hd_sop[i] && (hd_dest[i] == PORT_BITS'(o));
            end
        end

        psw_out_arbiter #(
            .NUM_IN (NUM_PORTS)
        ) arb_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req[o]),
            .xfer      (fire[o]),
            .xfer_last (out_last[o]),
            .owner_vld (own_vld[o]),
            .owner_idx (own_idx[o])
        );

        always_comb begin
            out_valid[o] = own_vld[o] && hd_valid[own_idx[o]];
            out_data[o]  = hd_data[own_idx[o]];
            out_last[o]  = hd_last[own_idx[o]];
            fire[o]      = out_valid[o] && out_ready[o];
        end

        // R6: an offered word is held until it is taken
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o])
            |=> (out_valid[o] && $stable(out_data[o]) && $stable(out_last[o])));
    end

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            for (int o = 0; o < NUM_PORTS; o++) begin
                rd_by[i][o] = fire[o] && (own_idx[o] == PORT_BITS'(i));
            end
            pop[i] = |rd_by[i];
        end
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        // R4: no input is drained by two outputs at once
        assert_single_reader_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rd_by[i]));
    end

endmodule

// File: tb/psw_switch_tb.sv
`timescale 1ns/1ps
module psw_switch_tb_top;

    localparam int DW = 16;
    localparam int PB = 2;
    localparam int DP = 4;
    localparam int NP = 1 << PB;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NP-1:0]         in_valid;
    logic [NP-1:0][DW-1:0] in_data;
    logic [NP-1:0]         in_last;
    logic [NP-1:0]         in_ready;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][DW-1:0] out_data;
    logic [NP-1:0]         out_last;
    logic [NP-1:0]         out_ready;

    always #5 clk = ~clk;

    psw_switch #(.DATA_W(DW), .PORT_BITS(PB), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [DW:0] sendq [NP][$];
    logic [DW:0] expq  [NP][NP][$];
    int          cur_src [NP];
    bit          osop [NP];
    int          acc_cnt [NP];
    int          rec0 [$];
    bit          rec_en = 0;
    int          max_fires = 0;
    bit          prev_stall [NP];
    logic [DW:0] prev_word [NP];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit all_empty();
        for (int a = 0; a < NP; a++) begin
            if (sendq[a].size() != 0) return 0;
            for (int b = 0; b < NP; b++) if (expq[a][b].size() != 0) return 0;
        end
        return 1;
    endfunction

    task automatic send_pkt(input int s, input int d, input int len);
        logic [DW-1:0] hdr;
        logic [DW-1:0] w;
        hdr = DW'($urandom);
        hdr[PB-1:0]    = PB'(d);
        hdr[2*PB-1:PB] = PB'(s);
        sendq[s].push_back({len == 1, hdr});
        expq[s][d].push_back({len == 1, hdr >> PB});
        for (int k = 1; k < len; k++) begin
            w = DW'($urandom);
            sendq[s].push_back({k == len - 1, w});
            expq[s][d].push_back({k == len - 1, w});
        end
    endtask

    task automatic cycle(input logic [NP-1:0] rdy, input int vprob, input bit rnd_rdy);
        int fires;
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            in_valid[i] = (sendq[i].size() > 0) && (($urandom % 100) < vprob);
            in_data[i]  = (sendq[i].size() > 0) ? sendq[i][0][DW-1:0] : '0;
            in_last[i]  = (sendq[i].size() > 0) ? sendq[i][0][DW] : 1'b0;
            out_ready[i] = rnd_rdy ? (($urandom % 100) < 70) : rdy[i];
        end
        #4;
        fires = 0;
        for (int i = 0; i < NP; i++) begin
            if (in_valid[i] && in_ready[i]) begin
                void'(sendq[i].pop_front());
                acc_cnt[i]++;
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (prev_stall[o]) begin
                check(out_valid[o] && ({out_last[o], out_data[o]} == prev_word[o]), "R6",
                      "held word", int'(out_data[o]), int'(prev_word[o][DW-1:0]));
            end
            prev_stall[o] = out_valid[o] && !out_ready[o];
            prev_word[o]  = {out_last[o], out_data[o]};
            if (out_valid[o] && out_ready[o]) begin
                logic [DW:0] e;
                fires++;
                if (osop[o]) begin
                    cur_src[o] = int'(out_data[o][PB-1:0]);
                    if (o == 0 && rec_en) rec0.push_back(cur_src[o]);
                end
                if (expq[cur_src[o]][o].size() == 0) begin
                    check(0, "R1", "unexpected word on output", o, -1);
                end else begin
                    e = expq[cur_src[o]][o].pop_front();
                    check({out_last[o], out_data[o]} == e, osop[o] ? "R2" : "R4",
                          osop[o] ? "header word" : "payload word",
                          int'({out_last[o], out_data[o]}), int'(e));
                end
                osop[o] = out_last[o];
            end
        end
        if (fires > max_fires) max_fires = fires;
    endtask

    task automatic drain(input int limit);
        for (int c = 0; c < limit && !all_empty(); c++) cycle('1, 100, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int o = 0; o < NP; o++) begin
            osop[o] = 1; cur_src[o] = 0; prev_stall[o] = 0; prev_word[o] = '0; acc_cnt[o] = 0;
        end
        rst_n = 0; in_valid = '0; in_data = '0; in_last = '0; out_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #2;
        // R8: idle outputs, open inputs after reset
        check(out_valid == '0, "R8", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == '1, "R8", "in_ready after reset", int'(in_ready), (1 << NP) - 1);

        // R5: four single-word packets contend for output 0, pointer starts at 0
        rec_en = 1;
        for (int s = 0; s < NP; s++) send_pkt(s, 0, 1);
        repeat (4) cycle('0, 100, 0);
        drain(50);
        // R5: input 2 alone moves the pointer to 3; then 0,1,3 contend -> 3 wins, wraps to 0,1
        send_pkt(2, 0, 1);
        drain(20);
        send_pkt(0, 0, 2); send_pkt(1, 0, 1); send_pkt(3, 0, 1);
        repeat (4) cycle('0, 100, 0);
        drain(50);
        rec_en = 0;
        check(rec0.size() == 8, "R5", "grants recorded", rec0.size(), 8);
        if (rec0.size() == 8) begin
            int exp_seq [8] = '{0, 1, 2, 3, 2, 3, 0, 1};
            for (int k = 0; k < 8; k++)
                check(rec0[k] == exp_seq[k], "R5", "round-robin order", rec0[k], exp_seq[k]);
        end

        // R3 / R7: fill input 0 behind a stalled output 1
        acc_cnt[0] = 0;
        send_pkt(0, 1, DP + 2);
        repeat (DP + 4) cycle('0, 100, 0);
        check(acc_cnt[0] == DP, "R3", "words taken while stalled", acc_cnt[0], DP);
        check(in_ready[0] == 1'b0, "R3", "in_ready when full", int'(in_ready[0]), 0);
        cycle(4'b0010, 100, 0);
        check(in_ready[0] == 1'b1, "R7", "in_ready while full and draining", int'(in_ready[0]), 1);
        check(acc_cnt[0] == DP + 1, "R7", "word taken in draining cycle", acc_cnt[0], DP + 1);
        drain(50);

        // R9: disjoint paths move together
        max_fires = 0;
        send_pkt(0, 2, 4); send_pkt(1, 3, 4);
        drain(50);
        check(max_fires >= 2, "R9", "concurrent transfers in a cycle", max_fires, 2);

        // R1..R4: random traffic with random backpressure
        for (int n = 0; n < 200; n++)
            send_pkt(int'($urandom % NP), int'($urandom % NP), 1 + int'($urandom % 5));
        for (int c = 0; c < 20000 && !all_empty(); c++) cycle('0, 70, 1);
        drain(200);
        check(all_empty(), "R3", "every packet delivered", int'(all_empty()), 1);

        finished = 1;
        summary();
    end

endmodule